// File: doc/BRIEF.md
# Comma Detect and Character Aligner

This block sits behind a deserializer that delivers one 10-bit chunk of received line bits per character clock. Bit 0 of each chunk is the earliest bit in serial order. The chunks arrive with an arbitrary bit phase, so the true character boundary can lie at any of ten bit offsets. The block keeps the previous chunk and forms a window from it and the current chunk. It searches that window for the 7-bit comma pattern at each of the ten offsets.

When a comma appears at an offset other than the one in use, the block moves its framing boundary at once. The character it emits in that cycle already starts with the comma. The same cycle also raises a one-cycle recenter strobe for the elastic buffer downstream. The character of that cycle is marked not valid. In encoded mode the search is always on. In raw 10-bit mode the search runs only while a comma-detect enable input is high.

Top module: `comma_aligner`

## Requirements
- R1: While reset is asserted, `char_out` is all zeros and `char_valid` and `realign` are low.
- R2: Each output character is registered. After the clock edge that takes chunk n, `char_out` equals bits off..off+9 of the 20-bit value {chunk n, chunk n-1}. Bit 0 of chunk n-1 is the earliest bit. After reset, off is 0, so the output is chunk n-1 unchanged.
- R3: A comma is the 7-bit pattern read from bit 0 upward as 0,0,1,1,1,1,1, or its complement 1,1,0,0,0,0,0. It may occupy window bits k..k+6 for any k from 0 to 9. If it does so with k different from off, off becomes k in that same cycle. The emitted character then holds the comma in bits 0 to 6.
- R4: A comma found at the offset already in use leaves the offset unchanged and raises no `realign`.
- R5: `realign` is high for exactly the output cycles in which the offset changed.
- R6: `char_valid` is low in each cycle in which `realign` is high, and high in every other cycle after reset.
- R7: If commas match at several offsets in one window, the lowest offset is taken.
- R8: With `enc_mode` high, alignment works whatever the level of `comma_en`.
- R9: With `enc_mode` low and `comma_en` low, commas are ignored: the offset stays as it is and `realign` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_chunk | input | 10 | Deserialized bits, bit 0 earliest |
| enc_mode | input | 1 | High: encoded mode, alignment always on |
| comma_en | input | 1 | Comma search enable used in raw mode |
| char_out | output | 10 | Aligned character |
| char_valid | output | 1 | Character is usable; low during a realignment cycle |
| realign | output | 1 | One-cycle recenter strobe to the elastic buffer |

## Verification
Alternating-bit streams carry a comma of either polarity placed at each of the ten bit slips. These streams separate a correct shift from an off-by-one boundary, and tell a correct move from the reset offset apart from a missed one. A second comma follows in each stream, either at the same slip or three bits further. This shows whether a realignment fires only on a real change and whether the new boundary holds afterwards. Each stream is run in encoded mode with the enable low, in raw mode with the enable high, and in raw mode with the enable low, which covers both the forced-on case and the ignored case. A single hand-built window holding commas at offsets 1 and 8 checks that the lowest offset wins.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;
  // Default character and comma widths
  localparam int DEF_CHAR_W  = 10;
  localparam int DEF_COMMA_W = 7;
  // Comma written as a number: bit 0 is first on the line (0,0,1,1,1,1,1)
  localparam logic [DEF_COMMA_W-1:0] DEF_COMMA_PAT = 7'b1111100;
endpackage

// File: rtl/comma_scan.sv
module comma_scan #(
  parameter int CHAR_W  = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = '0,
  parameter int OFF_W   = 4,
  localparam int SCAN_W = CHAR_W + COMMA_W - 1
) (
  input  logic [SCAN_W-1:0] win,
  output logic              hit,
  output logic [OFF_W-1:0]  hit_off
);
  logic [CHAR_W-1:0] match;

  // One comparator per candidate offset, both polarities
  for (genvar g = 0; g < CHAR_W; g++) begin : g_off
    assign match[g] = (win[g +: COMMA_W] == COMMA_PAT) ||
                      (win[g +: COMMA_W] == ~COMMA_PAT);
  end

  // Lowest matching offset wins
  always_comb begin
    hit_off = '0;
    for (int k = CHAR_W - 1; k >= 0; k--) begin
      if (match[k]) hit_off = OFF_W'(k);
    end
    hit = |match;
  end
endmodule

// File: rtl/char_slice.sv
module char_slice #(
  parameter int CHAR_W = 10,
  parameter int OFF_W  = 4
) (
  input  logic [2*CHAR_W-2:0] win,
  input  logic [OFF_W-1:0]    off,
  output logic [CHAR_W-1:0]   char_o
);
  always_comb begin
    char_o = win[CHAR_W-1:0];
    for (int k = 1; k < CHAR_W; k++) begin
      if (off == OFF_W'(k)) char_o = win[k +: CHAR_W];
    end
  end
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import comma_align_pkg::*;
#(
  parameter int CHAR_W  = DEF_CHAR_W,
  parameter int COMMA_W = DEF_COMMA_W,
  parameter logic [COMMA_W-1:0] COMMA_PAT = COMMA_W'(DEF_COMMA_PAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] rx_chunk,
  input  logic              enc_mode,
  input  logic              comma_en,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_valid,
  output logic              realign
);
  localparam int OFF_W  = $clog2(CHAR_W);
  localparam int WIN_W  = 2 * CHAR_W - 1;
  localparam int SCAN_W = CHAR_W + COMMA_W - 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // State
  logic [CHAR_W-1:0] prev_q, prev_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [CHAR_W-1:0] char_q, char_d;
  logic              valid_q, valid_d;
  logic              realign_q, realign_d;

  // Window: earlier chunk in the low bits; top bit of the current chunk
  // only matters once it moves into prev_q
  logic [WIN_W-1:0]  win;
  logic              hit;
  logic [OFF_W-1:0]  hit_off;
  logic              align_on;
  logic              shift_req;
  logic              load_en;

  assign win = {rx_chunk[CHAR_W-2:0], prev_q};

  comma_scan #(
    .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT), .OFF_W(OFF_W)
  ) scan_i (
    .win    (win[SCAN_W-1:0]),
    .hit    (hit),
    .hit_off(hit_off)
  );

  char_slice #(.CHAR_W(CHAR_W), .OFF_W(OFF_W)) slice_i (
    .win   (win),
    .off   (off_d),
    .char_o(char_d)
  );

  // Next state
  always_comb begin
    load_en   = 1'b1;                 // a new chunk arrives every cycle
    align_on  = enc_mode | comma_en;
    shift_req = align_on && hit && (hit_off != off_q);
    off_d     = shift_req ? hit_off : off_q;
    prev_d    = rx_chunk;
    valid_d   = !shift_req;
    realign_d = shift_req;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prev_q    <= '0;
      off_q     <= '0;
      char_q    <= '0;
      valid_q   <= 1'b0;
      realign_q <= 1'b0;
    end else if (load_en) begin
      prev_q    <= prev_d;
      off_q     <= off_d;
      char_q    <= char_d;
      valid_q   <= valid_d;
      realign_q <= realign_d;
    end
  end

  assign char_out   = char_q;
  assign char_valid = valid_q;
  assign realign    = realign_q;
endmodule

// File: rtl/comma_aligner_chk.sv
module comma_aligner_chk #(
  parameter int CHAR_W  = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = '0,
  parameter int OFF_W   = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              enc_mode,
  input logic              comma_en,
  input logic [CHAR_W-1:0] char_out,
  input logic              char_valid,
  input logic              realign,
  input logic [OFF_W-1:0]  off_q
);
  logic started;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) started <= 1'b0;
    else             started <= 1'b1;
  end

  // R3: a realigned character carries the comma in its low bits
  assert_comma_low_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    realign |-> (char_out[COMMA_W-1:0] == COMMA_PAT ||
                 char_out[COMMA_W-1:0] == ~COMMA_PAT));

  // R4 and R5: the boundary only moves together with the strobe
  assert_offset_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !realign |-> $stable(off_q));

  // R6: strobe and valid are exclusive
  assert_invalid_on_shift_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    realign |-> !char_valid);

  // R6: valid otherwise, once the first character is out
  assert_valid_steady_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (started && !realign) |-> char_valid);

  // R9: raw mode without enable never realigns
  assert_raw_disabled_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!enc_mode && !comma_en) |=> !realign);
endmodule

bind comma_aligner comma_aligner_chk #(
  .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT), .OFF_W(OFF_W)
) chk_i (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .enc_mode  (enc_mode),
  .comma_en  (comma_en),
  .char_out  (char_out),
  .char_valid(char_valid),
  .realign   (realign),
  .off_q     (off_q)
);

// File: tb/comma_aligner_tb_top.sv
module comma_aligner_tb_top;
  logic       clk;
  logic       rst_n;
  logic [9:0] rx_chunk;
  logic       enc_mode;
  logic       comma_en;
  logic [9:0] char_out;
  logic       char_valid;
  logic       realign;

  int tests;
  int fails;
  bit done;

  comma_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .rx_chunk(rx_chunk), .enc_mode(enc_mode),
    .comma_en(comma_en), .char_out(char_out), .char_valid(char_valid),
    .realign(realign)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    rx_chunk = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Serial stream: alternating bits with commas at 30+s and 70+s2
  task automatic run_case(input int s, input bit pol, input bit same,
                          input bit enc, input bit en);
    logic [99:0] sv;
    logic [9:0]  cm;
    int          s2;
    int          off;
    bit          on;
    bit          chg;
    string       tag;
    cm = pol ? 10'b1010000011 : 10'b0101111100;
    s2 = same ? s : (s + 3) % 10;
    for (int i = 0; i < 100; i++) sv[i] = i[0];
    sv[30 + s +: 10]  = cm;
    sv[70 + s2 +: 10] = cm;
    on  = enc | en;
    off = 0;
    do_reset();
    enc_mode = enc;
    comma_en = en;
    for (int n = 0; n < 10; n++) begin
      rx_chunk = sv[10*n +: 10];
      @(posedge clk);
      @(negedge clk);
      if (n == 0) continue;
      chg = 1'b0;
      if (on && n == 4 && s != off) begin chg = 1'b1; off = s; end
      if (on && n == 8 && s2 != off) begin chg = 1'b1; off = s2; end
      if (!on)                       tag = "R9";
      else if (enc && !en && n == 4) tag = "R8";
      else if (chg)                  tag = "R3";
      else if (n == 4 || n == 8)     tag = "R4";
      else                           tag = "R2";
      chk($sformatf("%s char s=%0d pol=%0d n=%0d", tag, s, pol, n),
          32'(char_out), 32'(sv[10*(n-1) + off +: 10]));
      chk($sformatf("R5 realign s=%0d n=%0d", s, n), 32'(realign), 32'(chg));
      chk($sformatf("R6 valid s=%0d n=%0d", s, n), 32'(char_valid), 32'(!chg));
    end
  endtask

  initial begin
    logic [19:0] pw;
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0; rx_chunk = '0; enc_mode = 1'b1; comma_en = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 char", 32'(char_out), 32'h0);
    chk("R1 valid", 32'(char_valid), 32'h0);
    chk("R1 realign", 32'(realign), 32'h0);

    for (int md = 0; md < 3; md++)
      for (int s = 0; s < 10; s++)
        for (int p = 0; p < 2; p++)
          for (int v = 0; v < 2; v++)
            run_case(s, p[0], v[0], md == 0, md == 1);

    // R7: commas at offsets 1 and 8 in one window; offset 1 wins
    pw = 20'hA83F9;
    do_reset();
    enc_mode = 1'b1; comma_en = 1'b0;
    rx_chunk = pw[9:0];
    @(posedge clk); @(negedge clk);
    rx_chunk = pw[19:10];
    @(posedge clk); @(negedge clk);
    chk("R7 char", 32'(char_out), 32'(pw[10:1]));
    chk("R7 realign", 32'(realign), 32'h1);
    chk("R7 valid", 32'(char_valid), 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule